// File: doc/BRIEF.md
# Approximate Single-Precision Reciprocal Unit

This block returns a fast estimate of 1/x for one binary32 value. The estimate is accurate to roughly twelve bits. It is meant for software that refines the estimate further, or that can accept the reduced precision. The source value arrives on its own 32-bit port. A 128-bit pass-through operand supplies the upper 96 bits of the 128-bit result, so the block can write one lane of a vector register while leaving the other three lanes unchanged.

For a normal input, the mantissa estimate comes from a small seed table indexed by the leading fraction bits. One Newton-Raphson step in unsigned fixed point then refines that seed. The result exponent comes from the input exponent, and it depends on whether the input fraction is zero.

Special cases bypass the arithmetic:
- zeros and denormals give a signed infinity;
- infinities give a signed zero;
- NaNs come back quiet;
- results that would fall below the smallest normal magnitude are flushed to a signed zero.

There is no rounding-mode input. The result is registered one clock after the input strobe.

Top module: `rcp_approx_unit`

## Requirements
- R1: For a normal input with biased exponent 1 to 252, the output is a normal value of the same sign, and |x·r − 1| ≤ 1.5·2^-12, where r is the output.
- R2: An input with biased exponent field 0 (zero or denormal) returns an infinity carrying the input sign: exponent 0xFF, fraction 0.
- R3: An infinite input (exponent 0xFF, fraction 0) returns a zero carrying the input sign.
- R4: A NaN input (exponent 0xFF, fraction non-zero) is returned with fraction bit 22 set and every other bit unchanged. A NaN with bit 22 already set comes back identical.
- R5: A result below the smallest normal magnitude is replaced by a signed zero, and no output ever has exponent 0 with a non-zero fraction. The flush rules by biased exponent are:
  - exponent 253 with a non-zero fraction is always flushed;
  - exponent 254 is always flushed;
  - exponent 252 or less is never flushed.
- R6: A normal input with zero fraction (a power of two) returns the exact reciprocal. The example 2^126 (0x7E800000) returns 2^-126 (0x00800000).
- R7: Result bits 127:32 equal bits 127:32 of the pass-through input sampled with the strobe.
- R8: `res_vld` is high exactly one clock after `src_vld` is high. Synchronous reset clears `res_vld` and the result.
- R9: The sign bit of every non-NaN result equals the input sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_vld | input | 1 | Input strobe, one operation per high cycle |
| lane_pass | input | 128 | Operand whose bits 127:32 are copied to the result |
| src_val | input | 32 | binary32 value to take the reciprocal of |
| res_vld | output | 1 | Result strobe |
| res_out | output | 128 | Reciprocal in bits 31:0, pass-through bits above |

## Verification
Every result is due exactly one rising edge after the cycle in which `src_vld` was high, since only the output register lies between the ports. The bench drives each operand at a falling edge and samples `res_out` and `res_vld` at the next falling edge. That places each sample half a period after the single capturing edge. For the latency rule, the bench also samples one falling edge later, after dropping the strobe, to confirm that `res_vld` has returned low.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [1:0] {
        KIND_ZERO = 2'd0,
        KIND_NORM = 2'd1,
        KIND_INF  = 2'd2,
        KIND_NAN  = 2'd3
    } fp_kind_e;

    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    // Seed for bucket idx: rounded 2^seed_w / (bucket midpoint), midpoint = 1 + (idx+0.5)/2^idx_w
    function automatic logic [31:0] seed_value(input int idx, input int idx_w, input int seed_w);
        longint num;
        longint den;
        num = longint'(1) << (seed_w + idx_w + 1);
        den = (longint'(1) << (idx_w + 1)) + 2 * longint'(idx) + 1;
        return 32'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/rcp_classify.sv
module rcp_classify
    import rcp_pkg::*;
(
    input  fp_word_t word_in,
    output fp_kind_e kind,
    output logic     frac_zero
);
    always_comb begin
        frac_zero = (word_in.frac == '0);
        if (word_in.exp == '0)
            kind = KIND_ZERO;
        else if (word_in.exp == EXP_ALL1)
            kind = frac_zero ? KIND_INF : KIND_NAN;
        else
            kind = KIND_NORM;
    end
endmodule

// File: rtl/rcp_seed_rom.sv
module rcp_seed_rom #(
    parameter int IDX_W  = 6,
    parameter int SEED_W = 12
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [SEED_W-1:0] seed
);
    localparam int DEPTH = 1 << IDX_W;

    logic [SEED_W-1:0] table_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        assign table_q[gi] = SEED_W'(rcp_pkg::seed_value(gi, IDX_W, SEED_W));
    end

    assign seed = table_q[idx];
endmodule

// File: rtl/rcp_newton.sv
module rcp_newton #(
    parameter int IDX_W  = 6,
    parameter int SEED_W = 12,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W-1:0] frac_in,
    output logic [FRAC_W-1:0] frac_out
);
    localparam int D_W  = FRAC_W + 1;         // 1.f divisor
    localparam int P_W  = D_W + SEED_W;       // d * y0
    localparam int P_FP = FRAC_W + SEED_W;    // binary point of product
    localparam int T_W  = P_W + 1;            // 2 - d*y0
    localparam int Y_W  = SEED_W + T_W;       // y0 * t
    localparam int Y_FP = SEED_W + P_FP;      // binary point of refined value

    logic [SEED_W-1:0] seed;
    logic [D_W-1:0]    divisor;
    logic [P_W-1:0]    prod;
    logic [T_W-1:0]    two_c;
    logic [T_W-1:0]    corr;
    logic [Y_W-1:0]    refined;

    rcp_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_rom (
        .idx  (frac_in[FRAC_W-1 -: IDX_W]),
        .seed (seed)
    );

    always_comb begin
        divisor = {1'b1, frac_in};
        prod    = P_W'(divisor) * P_W'(seed);
        two_c   = '0;
        two_c[P_FP+1] = 1'b1;
        corr    = two_c - T_W'(prod);
        refined = Y_W'(seed) * Y_W'(corr);
        if (refined[Y_W-1:Y_FP] != '0)
            frac_out = '1;                    // estimate reached 1.0: clamp below
        else if (!refined[Y_FP-1])
            frac_out = '0;                    // estimate fell under 0.5: clamp at 0.5
        else
            frac_out = refined[Y_FP-2 -: FRAC_W];
    end
endmodule

// File: rtl/rcp_approx_unit.sv
module rcp_approx_unit
    import rcp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int SEED_W = 12,
    parameter int LANE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_vld,
    input  logic [LANE_W-1:0] lane_pass,
    input  logic [31:0]       src_val,
    output logic              res_vld,
    output logic [LANE_W-1:0] res_out
);
    localparam int XE_W = EXP_W + 2;
    localparam logic signed [XE_W-1:0] BIAS_EXACT = XE_W'(254);
    localparam logic signed [XE_W-1:0] BIAS_APPRX = XE_W'(253);

    fp_word_t                src;
    fp_word_t                lane_res;
    fp_kind_e                kind;
    logic                    frac_zero;
    logic [FRAC_W-1:0]       est_frac;
    logic signed [XE_W-1:0]  new_exp;
    logic                    flush;

    assign src = fp_word_t'(src_val);

    rcp_classify u_cls (
        .word_in   (src),
        .kind      (kind),
        .frac_zero (frac_zero)
    );

    rcp_newton #(.IDX_W(IDX_W), .SEED_W(SEED_W), .FRAC_W(FRAC_W)) u_nr (
        .frac_in  (src.frac),
        .frac_out (est_frac)
    );

    always_comb begin
        new_exp  = (frac_zero ? BIAS_EXACT : BIAS_APPRX) - $signed({2'b00, src.exp});
        flush    = (new_exp < XE_W'(1));
        lane_res = '{sgn: src.sgn, exp: '0, frac: '0};
        unique case (kind)
            KIND_ZERO: lane_res.exp = EXP_ALL1;
            KIND_INF:  lane_res.exp = '0;
            KIND_NAN: begin
                lane_res.exp  = EXP_ALL1;
                lane_res.frac = src.frac | {1'b1, {(FRAC_W-1){1'b0}}};
            end
            default: begin
                if (!flush) begin
                    lane_res.exp  = new_exp[EXP_W-1:0];
                    lane_res.frac = frac_zero ? '0 : est_frac;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            res_out <= '0;
        end else begin
            res_vld <= src_vld;
            if (src_vld)
                res_out <= {lane_pass[LANE_W-1:32], lane_res};
        end
    end

    assert_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        src_vld |=> res_vld);
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !src_vld |=> !res_vld);
    assert_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        src_vld |=> res_out[LANE_W-1:32] == $past(lane_pass[LANE_W-1:32]));
    assert_zero_in_R2: assert property (@(posedge clk) disable iff (rst)
        (src_vld && src_val[30:23] == 8'h00) |=>
        (res_out[30:0] == 31'h7F800000 && res_out[31] == $past(src_val[31])));
    assert_inf_in_R3: assert property (@(posedge clk) disable iff (rst)
        (src_vld && src_val[30:0] == 31'h7F800000) |=>
        (res_out[30:0] == 31'h0 && res_out[31] == $past(src_val[31])));
    assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (src_vld && src_val[30:23] == 8'hFF && src_val[22:0] != 23'h0) |=>
        (res_out[31:0] == ($past(src_val) | 32'h00400000)));
    assert_no_denorm_R5: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> !(res_out[30:23] == 8'h00 && res_out[22:0] != 23'h0));
    assert_sign_R9: assert property (@(posedge clk) disable iff (rst)
        (src_vld && !(src_val[30:23] == 8'hFF && src_val[22:0] != 23'h0)) |=>
        res_out[31] == $past(src_val[31]));
endmodule

// File: tb/sim_rcp_approx_unit.sv
module sim_rcp_approx_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         src_vld;
    logic [127:0] lane_pass;
    logic [31:0]  src_val;
    logic         res_vld;
    logic [127:0] res_out;

    int n_vec  = 0;
    int n_miss = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    rcp_approx_unit u0 (
        .clk(clk), .rst(rst), .src_vld(src_vld), .lane_pass(lane_pass),
        .src_val(src_val), .res_vld(res_vld), .res_out(res_out)
    );

    function automatic real frac_real(input logic [22:0] f);
        return 1.0 + real'(f) / 8388608.0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // drive one operand; result sampled at following falling edge
    task automatic apply(input logic [127:0] pw, input logic [31:0] s, output logic [31:0] r);
        @(negedge clk);
        lane_pass = pw; src_val = s; src_vld = 1'b1;
        @(negedge clk);
        src_vld = 1'b0;
        chk(res_vld === 1'b1, "R8 strobe", {127'b0, res_vld}, 128'd1);
        r = res_out[31:0];
    endtask

    task automatic expect_word(input logic [31:0] s, input logic [31:0] e, input string tag);
        logic [31:0] r;
        apply({96'h0, 32'h0}, s, r);
        chk(r === e, tag, {96'h0, r}, {96'h0, e});
    endtask

    task automatic t_reset();
        rst = 1'b1; src_vld = 1'b0; lane_pass = '0; src_val = '0;
        repeat (3) @(negedge clk);
        chk(res_vld === 1'b0 && res_out === '0, "R8 reset", res_out, 128'h0);
        rst = 1'b0;
    endtask

    task automatic approx_check(input logic [31:0] s);
        logic [31:0] r;
        real prod, err;
        apply('0, s, r);
        prod = frac_real(s[22:0]) * frac_real(r[22:0]) *
               (2.0 ** real'(int'(s[30:23]) + int'(r[30:23]) - 254));
        err = (prod > 1.0) ? prod - 1.0 : 1.0 - prod;
        chk(r[30:23] != 8'h00 && r[30:23] != 8'hFF && err <= 1.5 / 4096.0,
            "R1 error bound", {96'h0, r}, {96'h0, s});
        chk(r[31] === s[31], "R9 sign", {96'h0, r}, {96'h0, s});
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] v;
            logic [7:0]  e;
            v = rnd();
            e = 8'(1 + (rnd() % 252));
            approx_check({v[31], e, v[22:0]});
        end
        approx_check(32'h3F800001);
        approx_check(32'h3FFFFFFF);
        approx_check(32'h00800001);
        approx_check(32'hBF7FFFFF);
    endtask

    task automatic t_powers();
        expect_word(32'h3F800000, 32'h3F800000, "R6 one");
        expect_word(32'h40000000, 32'h3F000000, "R6 two");
        expect_word(32'hC0800000, 32'hBE800000, "R6 minus four");
        expect_word(32'h00800000, 32'h7E800000, "R6 min normal");
        expect_word(32'h7E800000, 32'h00800000, "R6 2^126");
    endtask

    task automatic t_zeros();
        expect_word(32'h00000000, 32'h7F800000, "R2 +0");
        expect_word(32'h80000000, 32'hFF800000, "R2 -0");
        expect_word(32'h00000001, 32'h7F800000, "R2 +denorm");
        expect_word(32'h807FFFFF, 32'hFF800000, "R2 -denorm");
    endtask

    task automatic t_infs();
        expect_word(32'h7F800000, 32'h00000000, "R3 +inf");
        expect_word(32'hFF800000, 32'h80000000, "R3 -inf");
    endtask

    task automatic t_nans();
        expect_word(32'h7F800001, 32'h7FC00001, "R4 snan");
        expect_word(32'hFFA5A5A5, 32'hFFE5A5A5, "R4 neg snan");
        expect_word(32'h7FC12345, 32'h7FC12345, "R4 qnan kept");
    endtask

    task automatic t_flush();
        logic [31:0] r;
        expect_word(32'h7E800C01, 32'h00000000, "R5 upper bound flushed");
        expect_word(32'hFE800C01, 32'h80000000, "R5 neg flushed");
        expect_word(32'h7E800001, 32'h00000000, "R5 exp253 frac1");
        expect_word(32'h7F000000, 32'h00000000, "R5 exp254");
        expect_word(32'hFF7FFFFF, 32'h80000000, "R5 max finite");
        apply('0, 32'h7E7FE800, r);
        chk(r[30:23] == 8'h01, "R5 lower bound kept", {96'h0, r}, {96'h0, 32'h00800000});
        approx_check(32'h7E7FFFFF);
    endtask

    task automatic t_lanes();
        logic [31:0] r;
        apply({96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'hFFFF_FFFF}, 32'h40000000, r);
        chk(res_out[127:32] === 96'hDEAD_BEEF_0123_4567_89AB_CDEF && r === 32'h3F000000,
            "R7 lanes", res_out, {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h3F000000});
    endtask

    task automatic t_latency();
        logic [31:0] r;
        apply('0, 32'h3F800000, r);
        @(negedge clk);
        chk(res_vld === 1'b0, "R8 drop", {127'b0, res_vld}, 128'd0);
        chk(res_out[31:0] === 32'h3F800000, "R8 hold", res_out, {96'h0, 32'h3F800000});
    endtask

    initial begin
        #(5.0 * 100000);
        n_miss++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_powers();
        t_zeros();
        t_infs();
        t_nans();
        t_flush();
        t_lanes();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule